// File: doc/BRIEF.md
# Linked Page-Table Address Translator

This block converts the linear input addresses of a trace-buffer writer into physical memory addresses. The translation data sits in memory as a chain of 4KB table pages. Each table page covers one 1MB window of input space. It holds up to 256 data-page pointers, and it carries two link entries that point to its neighbours in the chain, one toward lower windows and one toward higher windows. Every entry is 64 bits wide. Bits [PW-1:12] give the page number and bit 0 marks the entry as valid. All other bits are ignored.

The block caches one pointer: the table page of the window it last visited. A request in that same window costs a single entry read. A request in another window makes the block step along the chain, one link read per hop, until it reaches the target window. It then reads the data entry. The result is either a translated address or a fault. The input base and the table base are captured only while the block is disabled. Enabling the block places the cache at window 0, at the table base.

Top module: `linked_xlat`

## Requirements
- R1: While `en` is low, `req_ready` is low, and no response or memory read is produced. Dropping `en` while a request is in flight abandons that request, and it gets no response.
- R2: A request whose address is below the input base gets a fault response in the cycle after acceptance (`rsp_valid`=1, `rsp_fault`=1), and no memory read is made.
- R3: A request in the cached window makes exactly one memory read, at table address + 8 × offset[19:12]. The offset is the request address minus the input base.
- R4: When the data entry has bit 0 set, the response is non-faulting and its address is {entry[PW-1:12], offset[11:0]}.
- R5: When the data entry has bit 0 clear, the response is a fault.
- R6: A request in a higher window reads the link entry at table address + 0xFF8 (entry 511). Each valid link moves the cache up one window and to the linked page.
- R7: A request in a lower window reads the link entry at table address + 0xFF0 (entry 510). Each valid link moves the cache down one window.
- R8: A link entry with bit 0 clear ends the walk with a fault response. Hops already taken stay in the cache, and the failed hop is not taken.
- R9: After a walk, a further request in the reached window needs only one memory read.
- R10: The input base (bits [19:0] forced to zero) and the table base are captured only while `en` is low. Changes made while `en` is high have no effect.
- R11: Raising `en` resets the cached window to index 0 at the captured table base.
- R12: Only one request is handled at a time. `req_ready` stays low from acceptance until the response has been presented, and at most one memory read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enable; configuration is captured while low |
| cfg_in_base | input | AW | Input base address (1MB aligned) |
| cfg_tbl_base | input | PW | Physical address of the first table page |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_addr | input | AW | Linear input address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_addr | output | PW | Translated physical address (zero on fault) |
| mem_rd_en | output | 1 | One-cycle table-entry read strobe |
| mem_rd_addr | output | PW | Byte address of the 64-bit entry |
| mem_rd_valid | input | 1 | Read data present |
| mem_rd_data | input | 64 | Entry read from memory |

## Verification
A wrong cached window or table pointer does not show up at once. It shows up on the next request that leaves the window, or on the next request that depends on it. There it appears as an extra or missing link read, a link read of the wrong entry, or a data read from the wrong page, within a few cycles of acceptance. The tests therefore chain walks up, walks down, a failed hop and repeated same-window requests. For each request they count the reads and log their addresses, so a corrupted cache shows in the read trace of the following request as well as in the returned address.

// File: rtl/linked_xlat.sv
module linked_xlat #(
  parameter int AW = 40,
  parameter int PW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] cfg_in_base,
  input  logic [PW-1:0] cfg_tbl_base,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic          rsp_fault,
  output logic [PW-1:0] rsp_addr,
  output logic          mem_rd_en,
  output logic [PW-1:0] mem_rd_addr,
  input  logic          mem_rd_valid,
  input  logic [63:0]   mem_rd_data
);

  localparam int WW = AW - 20;
  localparam int TW = PW - 12;

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_LINK, S_DATA} st_t;

  st_t           st;
  logic [AW-1:0] in_base_q;
  logic [AW-1:0] off_q;
  logic [TW-1:0] cur_tbl;
  logic [WW-1:0] cur_win;

  wire          accept  = req_valid && req_ready;
  wire          below   = req_addr < in_base_q;
  wire [WW-1:0] tgt_win = off_q[AW-1:20];
  wire          go_up   = tgt_win > cur_win;
  wire          unused_bits = ^{mem_rd_data[63:PW], mem_rd_data[11:1],
                                cfg_in_base[19:0], cfg_tbl_base[11:0]};

  assign req_ready = en && (st == S_IDLE) && !rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      in_base_q   <= '0;
      off_q       <= '0;
      cur_tbl     <= '0;
      cur_win     <= '0;
      rsp_valid   <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_addr    <= '0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
    end else if (!en) begin
      st        <= S_IDLE;
      in_base_q <= {cfg_in_base[AW-1:20], 20'd0};
      cur_tbl   <= cfg_tbl_base[PW-1:12];
      cur_win   <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      mem_rd_en <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      mem_rd_en <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (below) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_addr  <= '0;
          end else begin
            off_q <= req_addr - in_base_q;
            st    <= S_WALK;
          end
        end
        S_WALK: begin
          mem_rd_en <= 1'b1;
          if (tgt_win == cur_win) begin
            mem_rd_addr <= {cur_tbl, 1'b0, off_q[19:12], 3'b000};
            st          <= S_DATA;
          end else begin
            mem_rd_addr <= {cur_tbl, (go_up ? 9'h1FF : 9'h1FE), 3'b000};
            st          <= S_LINK;
          end
        end
        S_LINK: if (mem_rd_valid) begin
          if (mem_rd_data[0]) begin
            cur_tbl <= mem_rd_data[PW-1:12];
            cur_win <= go_up ? cur_win + WW'(1) : cur_win - WW'(1);
            st      <= S_WALK;
          end else begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_addr  <= '0;
            st        <= S_IDLE;
          end
        end
        S_DATA: if (mem_rd_valid) begin
          rsp_valid <= 1'b1;
          rsp_fault <= !mem_rd_data[0];
          rsp_addr  <= mem_rd_data[0] ? {mem_rd_data[PW-1:12], off_q[11:0]} : '0;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_quiet_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !rsp_valid && !mem_rd_en);

  p_below_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && below |=> rsp_valid && rsp_fault && !mem_rd_en);

  p_bad_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en && st == S_DATA && mem_rd_valid && !mem_rd_data[0] |=> rsp_valid && rsp_fault);

  p_hop_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en && st == S_LINK && mem_rd_valid && mem_rd_data[0] |=> cur_win != $past(cur_win));

  p_cfg_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) |-> $stable(in_base_q));

  p_busy_after_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  p_no_read_with_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_rd_en);

endmodule

// File: tb/linked_xlat_tb_top.sv
module linked_xlat_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [39:0] cfg_in_base = 40'h0;
  logic [39:0] cfg_tbl_base = 40'h0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [39:0] req_addr = 40'h0;
  logic        rsp_valid, rsp_fault;
  logic [39:0] rsp_addr;
  logic        mem_rd_en;
  logic [39:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [63:0] mem_rd_data;

  always #4 clk = ~clk;

  linked_xlat #(.AW(40), .PW(40)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cfg_in_base(cfg_in_base), .cfg_tbl_base(cfg_tbl_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  localparam logic [39:0] T0 = 40'h10000, T1 = 40'h20000, T2 = 40'h30000;

  bit [63:0]   mem_m [bit [39:0]];
  int          n_tests = 0, n_fail = 0;
  int          rd_count = 0;
  logic [39:0] rd_log [0:7];
  bit          overlap_err = 1'b0;
  bit          done = 1'b0;

  initial begin
    bit          pend = 1'b0;
    logic [39:0] pend_a = '0;
    int          wait_n = 0;
    mem_rd_valid = 1'b0;
    mem_rd_data  = '0;
    forever begin
      @(posedge clk);
      mem_rd_valid <= 1'b0;
      if (pend) begin
        if (wait_n == 0) begin
          mem_rd_valid <= 1'b1;
          mem_rd_data  <= mem_m.exists(pend_a) ? mem_m[pend_a] : 64'h0;
          pend = 1'b0;
        end else wait_n--;
      end
      if (mem_rd_en) begin
        if (pend) overlap_err = 1'b1;
        if (rd_count < 8) rd_log[rd_count] = mem_rd_addr;
        rd_count++;
        pend = 1'b1; pend_a = mem_rd_addr; wait_n = 1;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_req(input logic [39:0] a, output logic f, output logic [39:0] pa,
                         output int nrd, output int lat, output logic rdy_after);
    rd_count = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rdy_after = req_ready;
    lat = 0;
    while (!rsp_valid && lat < 200) begin @(negedge clk); lat++; end
    f = rsp_fault; pa = rsp_addr; nrd = rd_count;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 ready while disabled", req_ready, 0);
    req_valid = 1'b1; req_addr = 40'h100000;
    rd_count = 0;
    repeat (4) begin
      @(negedge clk);
      check("R1 no response while disabled", rsp_valid, 0);
    end
    check("R1 no read while disabled", rd_count, 0);
    req_valid = 1'b0;
  endtask

  task automatic t_same_window;
    logic f; logic [39:0] pa; int n, l; logic r;
    run_req(40'h100ABC, f, pa, n, l, r);
    check("R3 read count", n, 1);
    check("R3 read address", rd_log[0], T0);
    check("R4 fault", f, 0);
    check("R4 address", pa, 40'h12_3456_7ABC);
    check("R12 busy after accept", r, 0);
  endtask

  task automatic t_invalid_data;
    logic f; logic [39:0] pa; int n, l; logic r;
    run_req(40'h105010, f, pa, n, l, r);
    check("R3 index address", rd_log[0], T0 + 40'h28);
    check("R5 fault on clear entry", f, 1);
  endtask

  task automatic t_below_base;
    logic f; logic [39:0] pa; int n, l; logic r;
    run_req(40'h0FFFFF, f, pa, n, l, r);
    check("R2 fault", f, 1);
    check("R2 latency", l, 0);
    check("R2 no read", n, 0);
  endtask

  task automatic t_walk_up;
    logic f; logic [39:0] pa; int n, l; logic r;
    run_req(40'h303004, f, pa, n, l, r);
    check("R6 reads", n, 3);
    check("R6 first link", rd_log[0], T0 + 40'hFF8);
    check("R6 second link", rd_log[1], T1 + 40'hFF8);
    check("R6 data read", rd_log[2], T2 + 40'h18);
    check("R6 address", pa, 40'h77_0000_0004);
  endtask

  task automatic t_cached;
    logic f; logic [39:0] pa; int n, l; logic r;
    run_req(40'h303FFF, f, pa, n, l, r);
    check("R9 single read", n, 1);
    check("R9 address", pa, 40'h77_0000_0FFF);
  endtask

  task automatic t_walk_down;
    logic f; logic [39:0] pa; int n, l; logic r;
    run_req(40'h200ABC, f, pa, n, l, r);
    check("R7 reads", n, 2);
    check("R7 prev link", rd_log[0], T2 + 40'hFF0);
    check("R7 data read", rd_log[1], T1);
    check("R7 address", pa, 40'h44_4440_0ABC);
  endtask

  task automatic t_bad_link;
    logic f; logic [39:0] pa; int n, l; logic r;
    run_req(40'h400000, f, pa, n, l, r);
    check("R8 fault", f, 1);
    check("R8 reads", n, 2);
    check("R8 failing link", rd_log[1], T2 + 40'hFF8);
    run_req(40'h303008, f, pa, n, l, r);
    check("R8 kept hop reads", n, 1);
    check("R8 kept hop address", pa, 40'h77_0000_0008);
  endtask

  task automatic t_cfg_locked;
    logic f; logic [39:0] pa; int n, l; logic r;
    cfg_in_base = 40'h0; cfg_tbl_base = 40'h90000;
    run_req(40'h100ABC, f, pa, n, l, r);
    check("R10 reads", n, 3);
    check("R10 data read", rd_log[2], T0);
    check("R10 address", pa, 40'h12_3456_7ABC);
  endtask

  task automatic t_reenable;
    logic f; logic [39:0] pa; int n, l; logic r;
    @(negedge clk);
    en = 1'b0;
    cfg_in_base = 40'h312345; cfg_tbl_base = T1;
    repeat (3) @(negedge clk);
    en = 1'b1;
    run_req(40'h300123, f, pa, n, l, r);
    check("R11 reads", n, 1);
    check("R11 read address", rd_log[0], T1);
    check("R11 address", pa, 40'h44_4440_0123);
    run_req(40'h2FFFFF, f, pa, n, l, r);
    check("R10 new base fault", f, 1);
    check("R10 new base no read", n, 0);
  endtask

  task automatic t_abort;
    logic f; logic [39:0] pa; int n, l; logic r;
    int seen = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 40'h400010;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    en = 1'b0;
    repeat (8) begin @(negedge clk); if (rsp_valid) seen++; end
    check("R1 abandoned request silent", seen, 0);
    en = 1'b1;
    run_req(40'h300123, f, pa, n, l, r);
    check("R1 after abort reads", n, 1);
    check("R1 after abort address", pa, 40'h44_4440_0123);
  endtask

  initial begin
    mem_m[T0 + 40'h0]   = 64'h12_3456_7001;
    mem_m[T0 + 40'hFF0] = {24'h0, T2} | 64'h1;
    mem_m[T0 + 40'hFF8] = {24'h0, T1} | 64'h1;
    mem_m[T1 + 40'h0]   = 64'h44_4440_0001;
    mem_m[T1 + 40'hFF0] = {24'h0, T0} | 64'h1;
    mem_m[T1 + 40'hFF8] = {24'h0, T2} | 64'h1;
    mem_m[T2 + 40'h18]  = 64'h77_0000_0001;
    mem_m[T2 + 40'hFF0] = {24'h0, T1} | 64'h1;
    mem_m[T2 + 40'hFF8] = 64'h0;
    cfg_in_base = 40'h100000; cfg_tbl_base = T0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    @(negedge clk); en = 1'b1;
    t_same_window();
    t_invalid_data();
    t_below_base();
    t_walk_up();
    t_cached();
    t_walk_down();
    t_bad_link();
    t_cfg_locked();
    t_reenable();
    t_abort();
    check("R12 single outstanding read", overlap_err, 0);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule